// File: doc/BRIEF.md
# Timer Host Register Interface

This block sits between a byte-wide host bus and up to three counting elements of a programmable interval timer. The host reaches it through a chip select, active-low read and write strobes and a two-bit address. Three addresses reach the counters and the fourth reaches a write-only command register. Through that command register the host programs each counter's access format and operating mode. It can also freeze a counter's count on the fly, or freeze the count and a status byte of several counters at once.

For each channel the block keeps the 16-bit count register that the counting element loads from, and an output latch that either follows the counting element or holds a frozen count. It also keeps a status latch and a null-count flag. Separate byte pointers for reads and writes let a program read and write the same two-byte counter in any interleaving. The counting element receives the stored mode bits, the count register and a one-cycle strobe when a complete new count has arrived. It reports back its live count, its output pin and the moment it takes a count from the count register.

All strobes are sampled on one system clock. An access takes effect in the clock cycle after its strobe is released. Read data is presented as a plain output with a qualifying enable while a counter is being read.

Top module: `tmr_regif`

## Requirements
- R1: With `cs_n` high, read and write strobes have no effect: no count register changes, no new-count strobe, and `rdata_en` stays low.
- R2: Address 3 selects the command register, which is write-only (a read there leaves `rdata_en` low). Addresses 0, 1 and 2 select channels 0, 1 and 2.
- R3: A command with bits 7:6 = channel number (0..2) and bits 5:4 non-zero programs that channel. Its `ch_mode` becomes bits 5:0 of the command, and its count register is cleared to zero.
- R4: Bits 5:4 of the mode set the byte format. 01 writes only the low byte, 10 writes only the high byte, and 11 writes the low byte and then the high byte. A byte not written stays zero. `ch_newcnt` pulses once for one cycle, only after the final byte of a count.
- R5: The null-count flag is set together with the new-count strobe, and cleared when `ch_loaded` is high for that channel.
- R6: A command with bits 5:4 = 00 latches the selected channel's live count. Reads return the frozen count until all bytes of the format have been read, and then follow the live count again. The channel's mode is not changed.
- R7: A second count latch (by either command) before the latched count has been read is ignored. The first frozen value is read.
- R8: A command with bits 7:6 = 11 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 latches counts and bit 4 = 0 latches status. The whole command is ignored when bit 0 is 1.
- R9: A latched status byte is {output pin in bit 7, null-count flag in bit 6, mode bits 5:0}, taken at the moment of latching.
- R10: When status is latched, the next read of that channel returns the status whatever the latch order. The following reads return the latched count, and reads after that return the live count.
- R11: Read and write byte pointers are independent. The sequence read low, write low, read high, write high on a two-byte channel reads both live bytes and stores the written count.
- R12: An access takes effect once, when its strobe is released, however many cycles the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address (3 = command, 0..2 = channel) |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Read data, valid while rdata_en is high |
| rdata_en | output | 1 | High while a channel is being read |
| ch_mode | output | NUM_CH*6 | Per-channel stored mode bits 5:0 |
| ch_cr | output | NUM_CH*2*BYTE_W | Per-channel count register |
| ch_newcnt | output | NUM_CH | One-cycle strobe when a full new count is stored |
| ch_null | output | NUM_CH | Per-channel null-count flag |
| ch_ce | input | NUM_CH*2*BYTE_W | Live count of each counting element |
| ch_out | input | NUM_CH | Output pin state of each counting element |
| ch_loaded | input | NUM_CH | Counting element took the count register this cycle |

## Verification
The bench builds the block with three channels, byte width 8 and programming leaving the null-count flag alone. This makes every address, and every channel crossed with every byte format, reachable in one short sweep. Count values are derived arithmetically from the channel and format numbers. Expected register contents, read bytes and status bytes are therefore computed rather than tabulated. The three channels also let one read-back command select a non-adjacent subset and leave a third channel live, which exercises the selection bits and the latch-ordering rules.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

   typedef enum logic [1:0] {
      FMT_NONE = 2'b00,
      FMT_LO   = 2'b01,
      FMT_HI   = 2'b10,
      FMT_BOTH = 2'b11
   } acc_fmt_e;

   localparam logic [1:0] CMD_ADDR = 2'b11;
   localparam logic [1:0] RB_CODE  = 2'b11;
   localparam int         MODE_W   = 6;

endpackage

// File: rtl/tmr_bus_sync.sv
module tmr_bus_sync #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              wr_done,
   output logic              rd_done,
   output logic [1:0]        acc_addr,
   output logic [BYTE_W-1:0] acc_data
);

   logic wr_act, rd_act, wr_q, rd_q;

   assign wr_act = ~cs_n & ~wr_n;
   assign rd_act = ~cs_n & ~rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         rd_q     <= 1'b0;
         acc_addr <= '0;
         acc_data <= '0;
      end else begin
         wr_q <= wr_act;
         rd_q <= rd_act;
         if (wr_act || rd_act) begin
            acc_addr <= addr;
            acc_data <= wdata;
         end
      end
   end

   assign wr_done = wr_q & ~wr_act;
   assign rd_done = rd_q & ~rd_act;

   // R12: a completed access is reported for exactly one cycle
   p_single_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
   import tmr_regif_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_done,
   input  logic              rd_done,
   input  logic [1:0]        acc_addr,
   input  logic [BYTE_W-1:0] acc_data,
   output logic [NUM_CH-1:0] prog,
   output logic [NUM_CH-1:0] latch_cnt,
   output logic [NUM_CH-1:0] latch_sts,
   output logic [NUM_CH-1:0] cnt_wr,
   output logic [NUM_CH-1:0] cnt_rd
);

   logic cmd_wr, is_rb, rb_ok;

   assign cmd_wr = wr_done && (acc_addr == CMD_ADDR);
   assign is_rb  = (acc_data[7:6] == RB_CODE);
   assign rb_ok  = cmd_wr && is_rb && !acc_data[0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_cw;
      assign sel_cw       = cmd_wr && !is_rb && (acc_data[7:6] == 2'(i));
      assign prog[i]      = sel_cw && (acc_data[5:4] != 2'b00);
      assign latch_cnt[i] = (sel_cw && (acc_data[5:4] == 2'b00)) ||
                            (rb_ok && acc_data[i+1] && !acc_data[5]);
      assign latch_sts[i] = rb_ok && acc_data[i+1] && !acc_data[4];
      assign cnt_wr[i]    = wr_done && (acc_addr == 2'(i));
      assign cnt_rd[i]    = rd_done && (acc_addr == 2'(i));
   end

   // R3: at most one channel is programmed by a command
   p_one_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(prog));
   // R2: a count byte and a command never come from the same access
   p_cmd_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr != '0) |-> (prog == '0 && latch_sts == '0));

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_regif_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter bit NULL_ON_PROG = 1'b0,
   localparam int CNT_W       = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog,
   input  logic              latch_cnt,
   input  logic              latch_sts,
   input  logic              cnt_wr,
   input  logic              cnt_rd,
   input  logic [BYTE_W-1:0] din,
   input  logic [CNT_W-1:0]  ce_val,
   input  logic              out_pin,
   input  logic              ce_loaded,
   output logic [MODE_W-1:0] mode,
   output logic [CNT_W-1:0]  cr,
   output logic              newcnt,
   output logic              null_cnt,
   output logic [BYTE_W-1:0] rd_byte
);

   acc_fmt_e            fmt;
   logic                wr_hi, rd_hi, ol_held, sts_held;
   logic [CNT_W-1:0]    ol, cnt_src;
   logic [BYTE_W-1:0]   sts;
   logic                word_done, null_set_prog;

   assign fmt = acc_fmt_e'(mode[5:4]);

   always_comb begin
      word_done = 1'b0;
      if (cnt_wr) begin
         unique case (fmt)
            FMT_LO, FMT_HI: word_done = 1'b1;
            FMT_BOTH:       word_done = wr_hi;
            default:        word_done = 1'b0;
         endcase
      end
   end

   if (NULL_ON_PROG) begin : g_null_prog
      assign null_set_prog = prog;
   end else begin : g_null_keep
      assign null_set_prog = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= '0;
         cr       <= '0;
         wr_hi    <= 1'b0;
         rd_hi    <= 1'b0;
         ol_held  <= 1'b0;
         ol       <= '0;
         sts_held <= 1'b0;
         sts      <= '0;
         newcnt   <= 1'b0;
      end else begin
         newcnt <= word_done;
         if (prog) begin
            mode     <= din[MODE_W-1:0];
            cr       <= '0;
            wr_hi    <= 1'b0;
            rd_hi    <= 1'b0;
            ol_held  <= 1'b0;
            sts_held <= 1'b0;
         end else begin
            if (cnt_wr) begin
               unique case (fmt)
                  FMT_LO: cr[BYTE_W-1:0]     <= din;
                  FMT_HI: cr[CNT_W-1:BYTE_W] <= din;
                  FMT_BOTH: begin
                     if (wr_hi) cr[CNT_W-1:BYTE_W] <= din;
                     else       cr[BYTE_W-1:0]     <= din;
                     wr_hi <= ~wr_hi;
                  end
                  default: ;
               endcase
            end
            if (latch_cnt && !ol_held) begin
               ol      <= ce_val;
               ol_held <= 1'b1;
            end
            if (latch_sts && !sts_held) begin
               sts      <= BYTE_W'({out_pin, null_cnt, mode});
               sts_held <= 1'b1;
            end
            if (cnt_rd) begin
               if (sts_held) begin
                  sts_held <= 1'b0;
               end else if (fmt == FMT_BOTH && !rd_hi) begin
                  rd_hi <= 1'b1;
               end else begin
                  rd_hi   <= 1'b0;
                  ol_held <= 1'b0;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          null_cnt <= 1'b0;
      else if (word_done || null_set_prog) null_cnt <= 1'b1;
      else if (ce_loaded)                  null_cnt <= 1'b0;
   end

   assign cnt_src = ol_held ? ol : ce_val;

   always_comb begin
      if (sts_held)
         rd_byte = sts;
      else if (fmt == FMT_HI || (fmt == FMT_BOTH && rd_hi))
         rd_byte = cnt_src[CNT_W-1:BYTE_W];
      else
         rd_byte = cnt_src[BYTE_W-1:0];
   end

   // R4: the new-count strobe only follows a count byte write
   p_newcnt_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      newcnt |-> $past(cnt_wr));
   // R3: programming empties the count register
   p_prog_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog |=> (cr == '0));
   // R5: a load report without a new count clears null-count
   p_null_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_loaded && !cnt_wr && !prog) |=> !null_cnt);
   // R6/R7: a held count stays frozen until read or reprogrammed
   p_ol_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ol_held && !cnt_rd && !prog) |=> ($stable(ol) && ol_held));
   // R9: a held status stays frozen until read or reprogrammed
   p_sts_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_held && !cnt_rd && !prog) |=> $stable(sts));

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
   import tmr_regif_pkg::*;
#(
   parameter int  NUM_CH       = 3,
   parameter int  BYTE_W       = 8,
   parameter bit  NULL_ON_PROG = 1'b0,
   localparam int CNT_W        = 2 * BYTE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     rd_n,
   input  logic                     wr_n,
   input  logic [1:0]               addr,
   input  logic [BYTE_W-1:0]        wdata,
   output logic [BYTE_W-1:0]        rdata,
   output logic                     rdata_en,
   output logic [NUM_CH*MODE_W-1:0] ch_mode,
   output logic [NUM_CH*CNT_W-1:0]  ch_cr,
   output logic [NUM_CH-1:0]        ch_newcnt,
   output logic [NUM_CH-1:0]        ch_null,
   input  logic [NUM_CH*CNT_W-1:0]  ch_ce,
   input  logic [NUM_CH-1:0]        ch_out,
   input  logic [NUM_CH-1:0]        ch_loaded
);

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("tmr_regif: NUM_CH must be 1..3");
   end
   if (BYTE_W < 8) begin : g_bad_w
      $error("tmr_regif: BYTE_W must be at least 8");
   end

   logic                          wr_done, rd_done;
   logic [1:0]                    acc_addr;
   logic [BYTE_W-1:0]             acc_data;
   logic [NUM_CH-1:0]             prog, latch_cnt, latch_sts, cnt_wr, cnt_rd;
   logic [NUM_CH-1:0][BYTE_W-1:0] rd_bytes;

   tmr_bus_sync #(.BYTE_W(BYTE_W)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .addr     (addr),
      .wdata    (wdata),
      .wr_done  (wr_done),
      .rd_done  (rd_done),
      .acc_addr (acc_addr),
      .acc_data (acc_data)
   );

   tmr_cmd_decode #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_done   (wr_done),
      .rd_done   (rd_done),
      .acc_addr  (acc_addr),
      .acc_data  (acc_data),
      .prog      (prog),
      .latch_cnt (latch_cnt),
      .latch_sts (latch_sts),
      .cnt_wr    (cnt_wr),
      .cnt_rd    (cnt_rd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      tmr_chan_regs #(.BYTE_W(BYTE_W), .NULL_ON_PROG(NULL_ON_PROG)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .prog      (prog[i]),
         .latch_cnt (latch_cnt[i]),
         .latch_sts (latch_sts[i]),
         .cnt_wr    (cnt_wr[i]),
         .cnt_rd    (cnt_rd[i]),
         .din       (acc_data),
         .ce_val    (ch_ce[i*CNT_W +: CNT_W]),
         .out_pin   (ch_out[i]),
         .ce_loaded (ch_loaded[i]),
         .mode      (ch_mode[i*MODE_W +: MODE_W]),
         .cr        (ch_cr[i*CNT_W +: CNT_W]),
         .newcnt    (ch_newcnt[i]),
         .null_cnt  (ch_null[i]),
         .rd_byte   (rd_bytes[i])
      );
   end

   assign rdata_en = ~cs_n & ~rd_n & (int'(addr) < NUM_CH);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rdata_en && addr == 2'(i)) rdata = rd_bytes[i];
      end
   end

   // R1: read data is only qualified while selected and strobed
   p_rden_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_en |-> (!cs_n && !rd_n));
   // R4: a single access completes at most one channel's count
   p_one_newcnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_newcnt));

endmodule

// File: tb/tmr_regif_bench.sv
module tmr_regif_bench;

   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rdata_en;
   logic [17:0] ch_mode;
   logic [47:0] ch_cr;
   logic [2:0]  ch_newcnt, ch_null;
   logic [47:0] ch_ce = '0;
   logic [2:0]  ch_out = '0, ch_loaded = '0;

   int n_chk = 0, n_err = 0;
   int nc[NCH];
   bit finished = 0;

   always #5 clk = ~clk;

   tmr_regif u_tmr_regif (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en),
      .ch_mode(ch_mode), .ch_cr(ch_cr), .ch_newcnt(ch_newcnt), .ch_null(ch_null),
      .ch_ce(ch_ce), .ch_out(ch_out), .ch_loaded(ch_loaded)
   );

   initial for (int i = 0; i < NCH; i++) nc[i] = 0;
   always @(negedge clk) for (int i = 0; i < NCH; i++) if (ch_newcnt[i]) nc[i]++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [1:0] a, logic [7:0] d, int hold = 1, bit sel = 1);
      @(negedge clk); addr = a; wdata = d; cs_n = !sel; wr_n = 1'b0;
      repeat (hold) @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic bus_rd(logic [1:0] a, output logic [7:0] d, output logic en, input bit sel = 1);
      @(negedge clk); addr = a; cs_n = !sel; rd_n = 1'b0;
      @(negedge clk); d = rdata; en = rdata_en;
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic rd_count(int c, int fmt, output logic [15:0] v);
      logic [7:0] b0, b1; logic en;
      v = '0;
      bus_rd(2'(c), b0, en);
      if (fmt == 1) v[7:0] = b0;
      else if (fmt == 2) v[15:8] = b0;
      else begin bus_rd(2'(c), b1, en); v = {b1, b0}; end
   endtask

   function automatic logic [15:0] fmask(int fmt, logic [15:0] x);
      return (fmt == 1) ? {8'h00, x[7:0]} : (fmt == 2) ? {x[15:8], 8'h00} : x;
   endfunction

   task automatic pulse_loaded(int c);
      @(negedge clk); ch_loaded[c] = 1'b1;
      @(negedge clk); ch_loaded = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, got; logic [7:0] b, cw; logic en; int n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R3 reset cr", ch_cr, '0);
      chk("R3 reset mode", ch_mode, '0);
      chk("R5 reset null", ch_null, '0);
      chk("R1 reset rdata_en", rdata_en, 0);

      // sweep channels x formats
      for (int c = 0; c < NCH; c++) begin
         for (int f = 1; f <= 3; f++) begin
            cw = {2'(c), 2'(f), 3'(c + f), 1'b0};
            bus_wr(2'd3, cw);
            chk("R3 mode bits", ch_mode[c*6 +: 6], cw[5:0]);
            chk("R3 cr cleared", ch_cr[c*16 +: 16], 0);
            v = 16'h1234 + 16'(c) * 16'h1111 + 16'(f) * 16'h0F0F;
            n0 = nc[c];
            if (f == 1) bus_wr(2'(c), v[7:0]);
            else if (f == 2) bus_wr(2'(c), v[15:8]);
            else begin
               bus_wr(2'(c), v[7:0]);
               chk("R4 no strobe after first byte", nc[c], n0);
               bus_wr(2'(c), v[15:8]);
            end
            chk("R4 count register", ch_cr[c*16 +: 16], fmask(f, v));
            chk("R4 single strobe", nc[c], n0 + 1);
            chk("R5 null set", ch_null[c], 1);
            pulse_loaded(c);
            chk("R5 null cleared", ch_null[c], 0);
            ch_ce[c*16 +: 16] = ~v;
            rd_count(c, f, got);
            chk("R6 live read", got, fmask(f, ~v));
            bus_wr(2'd3, {2'(c), 6'b000000});
            chk("R6 mode kept", ch_mode[c*6 +: 6], cw[5:0]);
            ch_ce[c*16 +: 16] = v ^ 16'h5A5A;
            bus_wr(2'd3, {2'(c), 6'b000000});
            ch_ce[c*16 +: 16] = 16'h0000 + 16'(c);
            rd_count(c, f, got);
            chk("R7 first latch wins", got, fmask(f, ~v));
            rd_count(c, f, got);
            chk("R6 released to live", got, fmask(f, 16'(c)));
         end
      end

      // R11 interleaved access on channel 1
      bus_wr(2'd3, 8'h70);
      ch_ce[16 +: 16] = 16'hBEEF;
      n0 = nc[1];
      bus_rd(2'd1, b, en); chk("R11 read low", b, 8'hEF);
      bus_wr(2'd1, 8'h11);
      bus_rd(2'd1, b, en); chk("R11 read high", b, 8'hBE);
      bus_wr(2'd1, 8'h22);
      chk("R11 stored count", ch_cr[16 +: 16], 16'h2211);
      chk("R11 one strobe", nc[1], n0 + 1);

      // R12 long strobe acts once
      bus_wr(2'd3, 8'h10);
      n0 = nc[0];
      bus_wr(2'd0, 8'h77, 6);
      chk("R12 single action", nc[0], n0 + 1);
      chk("R12 value", ch_cr[0 +: 16], 16'h0077);

      // R1 no chip select
      bus_wr(2'd0, 8'h99, 1, 0);
      chk("R1 write ignored", ch_cr[0 +: 16], 16'h0077);
      chk("R1 no strobe", nc[0], n0 + 1);
      bus_rd(2'd0, b, en, 0);
      chk("R1 read ignored", en, 0);

      // R2 command register not readable
      bus_rd(2'd3, b, en);
      chk("R2 command read", en, 0);
      bus_rd(2'd2, b, en);
      chk("R2 channel read enabled", en, 1);

      // read-back: ch0 count latch then status latch; ch2 both
      for (int c = 0; c < NCH; c++) pulse_loaded(c);
      bus_wr(2'd3, 8'h34);               // ch0 two-byte, mode bits 0x34
      bus_wr(2'd3, 8'hB7);               // ch2 two-byte, mode bits 0x37
      bus_wr(2'd0, 8'h01); bus_wr(2'd0, 8'h02);
      ch_out = 3'b001;
      ch_ce[0 +: 16]  = 16'h1357;
      ch_ce[32 +: 16] = 16'h2468;
      ch_ce[16 +: 16] = 16'hCAFE;
      bus_wr(2'd3, 8'hC3);               // reserved bit set: ignored
      ch_ce[0 +: 16] = 16'hAAAA;
      bus_rd(2'd0, b, en); chk("R8 reserved bit ignores command", b, 8'hAA);
      bus_rd(2'd0, b, en);
      ch_ce[0 +: 16] = 16'h1357;
      bus_wr(2'd3, 8'h00);               // ch0 count latch first
      bus_wr(2'd3, 8'hE2);               // then status only, ch0
      bus_wr(2'd3, 8'hC8);               // count+status, ch2
      ch_ce[0 +: 16] = '0; ch_ce[32 +: 16] = '0; ch_out = '0;
      bus_rd(2'd0, b, en); chk("R10 status first", b, 8'hF4);
      chk("R9 status fields ch0", b, {1'b1, 1'b1, 6'h34});
      bus_rd(2'd0, b, en); chk("R10 latched low", b, 8'h57);
      bus_rd(2'd0, b, en); chk("R10 latched high", b, 8'h13);
      bus_rd(2'd0, b, en); chk("R10 live after", b, 8'h00);
      bus_rd(2'd0, b, en);
      bus_rd(2'd1, b, en); chk("R8 unselected live", b, 8'hFE);
      bus_rd(2'd1, b, en);
      bus_rd(2'd2, b, en); chk("R9 status fields ch2", b, 8'h37);
      bus_rd(2'd2, b, en); chk("R8 ch2 latched low", b, 8'h68);
      bus_rd(2'd2, b, en); chk("R8 ch2 latched high", b, 8'h24);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule